// File: doc/BRIEF.md
# Display Controller Command Port Decoder

This block sits behind the command port of a tile-based video display controller. Each 16-bit word written to that port is either a one-word register update or one half of a two-word setup that loads the access address and the access code. The decoder remembers whether the second half of a setup is still outstanding. It keeps the 16-bit address and the 6-bit code, and it stores the 24 configuration registers, which it also drives out to the rest of the display pipeline.

When a setup completes, the decoder can launch a memory transfer. It picks the transfer kind from a configuration register and drives a one-cycle start pulse to the transfer engines. A fill transfer is only armed at that point; it launches on the next data-port write. Data-port reads and writes advance the address by the programmed step. The decoder also decodes the code into a memory target for each direction.

Command words arrive on a valid/ready pair. Ready is always high, so the block never applies back-pressure and takes a word in every cycle in which valid is high. When a command word arrives, it takes priority over any data-port or status-port strobe in the same cycle, and those strobes are dropped for that cycle. The register-write strobe and the transfer start pulse are plain one-cycle outputs with no back-pressure.

Top module: `cmd_port_decoder`

## Requirements
- R1: A command word accepted while no second word is awaited, whose bits 15:14 equal binary 10, is a register write. One cycle later, reg_wr_valid is high for exactly one cycle, with reg_wr_num equal to bits 12:8 and reg_wr_val equal to bits 7:0. The value appears in byte N of cfg_regs, and pending stays 0.
- R2: Any command word accepted while no second word is awaited loads address bits 13:0 from word bits 13:0 and keeps the latched upper address bits. It loads code bits 1:0 from word bits 15:14 and keeps code bits 5:2. A word that is not a register write sets pending.
- R3: A command word accepted while pending is 1 is a second word, whatever its top bits. It clears pending and sets address bits 15:14 from word bits 1:0, which are also latched for later first words. It sets code bits 5:2 from word bits 7:4 and keeps address bits 13:0 and code bits 1:0.
- R4: After a second word whose bit 7 is 1, the outcome depends on register 1 bit 4. If that bit is 1, register 23 bits 7:6 pick the action: value 2 sets fill_armed with no pulse, value 3 gives a one-cycle dma_start with dma_kind 3 (copy), and any other value gives dma_start with dma_kind 0 (external bus). If register 1 bit 4 is 0, no transfer starts.
- R5: While fill_armed is 1, the next data-port write gives a one-cycle dma_start with dma_kind 2 and clears fill_armed. Later data writes start nothing.
- R6: A status-port read, a data-port read or a data-port write clears pending.
- R7: A register write to a number of 11 or above is dropped while register 1 bit 2 is 0. No strobe appears and cfg_regs is unchanged.
- R8: Every data-port read or write adds register 15 to the address, modulo 2^16.
- R9: wr_target is 1 (video RAM) for code bits 3:0 equal to 1, 2 (colour RAM) for 3, 3 (vertical-scroll RAM) for 5, and 0 otherwise. rd_target is 1 for 0, 2 for 8, 3 for 4, and 0 otherwise.
- R10: After reset, the address, code, pending, fill_armed, strobes and all registers are zero, and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken (always high) |
| cmd_data | input | 16 | Command word |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status-port read strobe |
| reg_wr_valid | output | 1 | One-cycle register-write strobe |
| reg_wr_num | output | 5 | Number of the written register |
| reg_wr_val | output | 8 | Value written |
| cfg_regs | output | 192 | All configuration registers, byte N is register N |
| addr | output | 16 | Access address |
| code | output | 6 | Access code |
| pending | output | 1 | Second command word awaited |
| fill_armed | output | 1 | Fill waits for the next data write |
| wr_target | output | 2 | Memory target for data writes |
| rd_target | output | 2 | Memory target for data reads |
| dma_start | output | 1 | One-cycle transfer launch |
| dma_kind | output | 2 | Transfer kind: 0 external bus, 2 fill, 3 copy |

## Verification
The bench builds the decoder with its default parameters. These are a 16-bit address, 24 registers and a lock boundary at register 11, with the mode, step and transfer-select registers at 1, 15 and 23. With these values the locked step register can be shown to hold zero, so an early data write leaves the address where it was. Once unlocked, a step of 2 moves the address visibly across the upper-bit latch. All four values of the transfer-select field, and transfers with the enable bit cleared, are reachable through ordinary command sequences.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_CRAM  = 2'd2,
    TGT_VSRAM = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    XFER_BUS  = 2'd0,
    XFER_RSVD = 2'd1,
    XFER_FILL = 2'd2,
    XFER_COPY = 2'd3
  } xfer_e;

  localparam int CMD_W  = 16;
  localparam int NUM_W  = 5;
  localparam int CODE_W = 6;
endpackage

// File: rtl/cpd_regfile.sv
module cpd_regfile
  import cpd_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 24,
  parameter int LOCK_FROM  = 11,
  parameter int MODE_IDX   = 1,
  parameter int UNLOCK_BIT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_req,
  input  logic [NUM_W-1:0]          wr_num,
  input  logic [REG_W-1:0]          wr_val,
  output logic                      wr_acc,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);
  logic unlocked;

  assign unlocked = regs_flat[MODE_IDX*REG_W + UNLOCK_BIT];
  assign wr_acc   = wr_req && ((wr_num < NUM_W'(LOCK_FROM)) || unlocked);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic [REG_W-1:0] entry_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry_q <= '0;
      end else if (wr_acc && (wr_num == NUM_W'(i))) begin
        entry_q <= wr_val;
      end
    end
    assign regs_flat[i*REG_W +: REG_W] = entry_q;
  end
endmodule

// File: rtl/cpd_addr_code.sv
module cpd_addr_code
  import cpd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_v,
  input  logic [CMD_W-1:0]  cmd_d,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic [REG_W-1:0]  step,
  input  logic              xfer_en,
  input  logic [1:0]        xfer_sel,
  output logic              reg_req,
  output logic [NUM_W-1:0]  reg_num,
  output logic [REG_W-1:0]  reg_val,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CODE_W-1:0] code_q,
  output logic              pend_q,
  output logic              armed_q,
  output logic              start_q,
  output logic [1:0]        kind_q
);
  localparam int LOW_W = 14;
  localparam int HI_W  = ADDR_W - LOW_W;

  logic [HI_W-1:0] hi_q;
  logic first_w, second_w, port_acc, xfer_go;

  assign first_w  = cmd_v && !pend_q;
  assign second_w = cmd_v && pend_q;
  assign port_acc = data_wr || data_rd || stat_rd;
  assign reg_req  = first_w && (cmd_d[15:14] == 2'b10);
  assign reg_num  = cmd_d[8 +: NUM_W];
  assign reg_val  = cmd_d[REG_W-1:0];
  assign xfer_go  = second_w && cmd_d[7] && xfer_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      hi_q    <= '0;
      code_q  <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
      kind_q  <= XFER_BUS;
    end else begin
      start_q <= 1'b0;
      if (first_w) begin
        addr_q      <= {hi_q, cmd_d[LOW_W-1:0]};
        code_q[1:0] <= cmd_d[15:14];
        if (!reg_req) pend_q <= 1'b1;
      end else if (second_w) begin
        pend_q                  <= 1'b0;
        hi_q                    <= cmd_d[HI_W-1:0];
        addr_q[ADDR_W-1:LOW_W]  <= cmd_d[HI_W-1:0];
        code_q[CODE_W-1:2]      <= cmd_d[7:4];
        if (xfer_go) begin
          case (xfer_sel)
            2'b10:   armed_q <= 1'b1;
            2'b11: begin
              start_q <= 1'b1;
              kind_q  <= XFER_COPY;
            end
            default: begin
              start_q <= 1'b1;
              kind_q  <= XFER_BUS;
            end
          endcase
        end
      end else if (port_acc) begin
        pend_q <= 1'b0;
        if (data_wr || data_rd) addr_q <= addr_q + ADDR_W'(step);
        if (data_wr && armed_q) begin
          armed_q <= 1'b0;
          start_q <= 1'b1;
          kind_q  <= XFER_FILL;
        end
      end
    end
  end
endmodule

// File: rtl/cpd_target.sv
module cpd_target
  import cpd_pkg::*;
(
  input  logic [3:0] sel,
  output logic [1:0] wr_tgt,
  output logic [1:0] rd_tgt
);
  tgt_e w, r;

  always_comb begin
    case (sel)
      4'd1:    w = TGT_VRAM;
      4'd3:    w = TGT_CRAM;
      4'd5:    w = TGT_VSRAM;
      default: w = TGT_NONE;
    endcase
    case (sel)
      4'd0:    r = TGT_VRAM;
      4'd8:    r = TGT_CRAM;
      4'd4:    r = TGT_VSRAM;
      default: r = TGT_NONE;
    endcase
  end

  assign wr_tgt = w;
  assign rd_tgt = r;
endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
  import cpd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 24,
  parameter int LOCK_FROM  = 11,
  parameter int MODE_IDX   = 1,
  parameter int STEP_IDX   = 15,
  parameter int XSEL_IDX   = 23,
  parameter int UNLOCK_BIT = 2,
  parameter int XEN_BIT    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [15:0]               cmd_data,
  input  logic                      data_wr,
  input  logic                      data_rd,
  input  logic                      stat_rd,
  output logic                      reg_wr_valid,
  output logic [4:0]                reg_wr_num,
  output logic [REG_W-1:0]          reg_wr_val,
  output logic [NUM_REGS*REG_W-1:0] cfg_regs,
  output logic [ADDR_W-1:0]         addr,
  output logic [5:0]                code,
  output logic                      pending,
  output logic                      fill_armed,
  output logic [1:0]                wr_target,
  output logic [1:0]                rd_target,
  output logic                      dma_start,
  output logic [1:0]                dma_kind
);
  logic             rq, acc;
  logic [4:0]       rnum;
  logic [REG_W-1:0] rval;
  logic [REG_W-1:0] step;
  logic             xen;
  logic [1:0]       xsel;

  assign cmd_ready = 1'b1;
  assign step = cfg_regs[STEP_IDX*REG_W +: REG_W];
  assign xen  = cfg_regs[MODE_IDX*REG_W + XEN_BIT];
  assign xsel = cfg_regs[XSEL_IDX*REG_W + REG_W - 2 +: 2];

  cpd_addr_code #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ac (
    .clk(clk), .rst_n(rst_n), .cmd_v(cmd_valid), .cmd_d(cmd_data),
    .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd),
    .step(step), .xfer_en(xen), .xfer_sel(xsel),
    .reg_req(rq), .reg_num(rnum), .reg_val(rval),
    .addr_q(addr), .code_q(code), .pend_q(pending), .armed_q(fill_armed),
    .start_q(dma_start), .kind_q(dma_kind)
  );

  cpd_regfile #(
    .REG_W(REG_W), .NUM_REGS(NUM_REGS), .LOCK_FROM(LOCK_FROM),
    .MODE_IDX(MODE_IDX), .UNLOCK_BIT(UNLOCK_BIT)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_req(rq), .wr_num(rnum), .wr_val(rval),
    .wr_acc(acc), .regs_flat(cfg_regs)
  );

  cpd_target u_tg (.sel(code[3:0]), .wr_tgt(wr_target), .rd_tgt(rd_target));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_wr_valid <= 1'b0;
      reg_wr_num   <= '0;
      reg_wr_val   <= '0;
    end else begin
      reg_wr_valid <= acc;
      if (acc) begin
        reg_wr_num <= rnum;
        reg_wr_val <= rval;
      end
    end
  end
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 24,
  parameter int LOCK_FROM  = 11,
  parameter int MODE_IDX   = 1,
  parameter int STEP_IDX   = 15,
  parameter int UNLOCK_BIT = 2,
  parameter int XEN_BIT    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic [15:0]               cmd_data,
  input logic                      data_wr,
  input logic                      data_rd,
  input logic                      stat_rd,
  input logic                      reg_wr_valid,
  input logic [4:0]                reg_wr_num,
  input logic [NUM_REGS*REG_W-1:0] cfg_regs,
  input logic [ADDR_W-1:0]         addr,
  input logic [5:0]                code,
  input logic                      pending,
  input logic                      fill_armed,
  input logic                      dma_start,
  input logic [1:0]                dma_kind
);
  logic             is_first, is_regw, unlocked, xen;
  logic [REG_W-1:0] step;

  assign is_first = cmd_valid && !pending;
  assign is_regw  = is_first && (cmd_data[15:14] == 2'b10);
  assign unlocked = cfg_regs[MODE_IDX*REG_W + UNLOCK_BIT];
  assign xen      = cfg_regs[MODE_IDX*REG_W + XEN_BIT];
  assign step     = cfg_regs[STEP_IDX*REG_W +: REG_W];

  AST_REG_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    is_regw && (cmd_data[12:8] < 5'(LOCK_FROM)) |=> reg_wr_valid && (reg_wr_num == $past(cmd_data[12:8]))); // R1
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    is_first |=> (addr[13:0] == $past(cmd_data[13:0])) && (code[1:0] == $past(cmd_data[15:14]))); // R2
  AST_SECOND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && pending |=> !pending && (addr[13:0] == $past(addr[13:0]))); // R3
  AST_XFER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !xen |=> !dma_start); // R4
  AST_FILL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start && (dma_kind == 2'd2) |-> !fill_armed); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && (data_wr || data_rd || stat_rd) |=> !pending); // R6
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    is_regw && (cmd_data[12:8] >= 5'(LOCK_FROM)) && !unlocked |=> !reg_wr_valid); // R7
  AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && (data_wr || data_rd) |=> addr == $past(addr) + ADDR_W'($past(step))); // R8
endmodule

bind cmd_port_decoder cpd_checker #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .LOCK_FROM(LOCK_FROM),
  .MODE_IDX(MODE_IDX), .STEP_IDX(STEP_IDX), .UNLOCK_BIT(UNLOCK_BIT), .XEN_BIT(XEN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
  .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd),
  .reg_wr_valid(reg_wr_valid), .reg_wr_num(reg_wr_num), .cfg_regs(cfg_regs),
  .addr(addr), .code(code), .pending(pending), .fill_armed(fill_armed),
  .dma_start(dma_start), .dma_kind(dma_kind)
);

// File: tb/cmd_port_decoder_test.sv
`timescale 1ns/1ps
module cmd_port_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic data_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic cmd_ready, reg_wr_valid, pending, fill_armed, dma_start;
  logic [4:0] reg_wr_num;
  logic [7:0] reg_wr_val;
  logic [191:0] cfg_regs;
  logic [15:0] addr;
  logic [5:0] code;
  logic [1:0] wr_target, rd_target, dma_kind;

  always #4 clk = ~clk;

  cmd_port_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd),
    .reg_wr_valid(reg_wr_valid), .reg_wr_num(reg_wr_num), .reg_wr_val(reg_wr_val),
    .cfg_regs(cfg_regs), .addr(addr), .code(code), .pending(pending),
    .fill_armed(fill_armed), .wr_target(wr_target), .rd_target(rd_target),
    .dma_start(dma_start), .dma_kind(dma_kind)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pend;
    logic        armed;
    logic        rwv;
    logic [4:0]  rnum;
    logic [7:0]  rval;
    logic        dmas;
    logic [1:0]  kind;
    logic [1:0]  wt;
    logic [1:0]  rt;
    logic [7:0]  r1;
    logic [7:0]  r15;
    logic [7:0]  r23;
    logic        rdy;
  } obs_t;

  obs_t  q_exp[$];
  string q_req[$];
  int nchecks = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [15:0] m_addr = '0;
  logic [5:0]  m_code = '0;
  logic [1:0]  m_hi = '0;
  logic        m_pend = 1'b0, m_armed = 1'b0;
  logic [7:0]  m_r1 = '0, m_r15 = '0, m_r23 = '0;

  function automatic logic [1:0] wtgt(input logic [3:0] c);
    case (c)
      4'd1: return 2'd1;
      4'd3: return 2'd2;
      4'd5: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] rtgt(input logic [3:0] c);
    case (c)
      4'd0: return 2'd1;
      4'd8: return 2'd2;
      4'd4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic step(input logic cv, input logic [15:0] cd,
                      input logic dw, input logic dr, input logic sr, input string req);
    obs_t e;
    e = '0;
    @(negedge clk);
    cmd_valid = cv; cmd_data = cd; data_wr = dw; data_rd = dr; stat_rd = sr;
    if (cv) begin
      if (!m_pend) begin
        if (cd[15:14] == 2'b10) begin
          if (cd[12:8] < 5'd11 || m_r1[2]) begin
            e.rwv = 1'b1; e.rnum = cd[12:8]; e.rval = cd[7:0];
            if (cd[12:8] == 5'd1)  m_r1  = cd[7:0];
            if (cd[12:8] == 5'd15) m_r15 = cd[7:0];
            if (cd[12:8] == 5'd23) m_r23 = cd[7:0];
          end
        end else begin
          m_pend = 1'b1;
        end
        m_addr = {m_hi, cd[13:0]};
        m_code[1:0] = cd[15:14];
      end else begin
        m_pend = 1'b0;
        m_hi = cd[1:0];
        m_addr[15:14] = cd[1:0];
        m_code[5:2] = cd[7:4];
        if (m_code[5] && m_r1[4]) begin
          if (m_r23[7:6] == 2'b10) m_armed = 1'b1;
          else begin
            e.dmas = 1'b1;
            e.kind = (m_r23[7:6] == 2'b11) ? 2'd3 : 2'd0;
          end
        end
      end
    end else if (dw || dr || sr) begin
      m_pend = 1'b0;
      if (dw || dr) m_addr = m_addr + {8'h00, m_r15};
      if (dw && m_armed) begin
        m_armed = 1'b0; e.dmas = 1'b1; e.kind = 2'd2;
      end
    end
    e.addr = m_addr; e.code = m_code; e.pend = m_pend; e.armed = m_armed;
    e.wt = wtgt(m_code[3:0]); e.rt = rtgt(m_code[3:0]);
    e.r1 = m_r1; e.r15 = m_r15; e.r23 = m_r23; e.rdy = 1'b1;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; data_wr = 1'b0; data_rd = 1'b0; stat_rd = 1'b0;
    q_exp.push_back(e);
    q_req.push_back(req);
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      obs_t e, a;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      a = '0;
      a.addr = addr; a.code = code; a.pend = pending; a.armed = fill_armed;
      a.rwv = reg_wr_valid; a.dmas = dma_start; a.wt = wr_target; a.rt = rd_target;
      a.r1 = cfg_regs[8 +: 8]; a.r15 = cfg_regs[120 +: 8]; a.r23 = cfg_regs[184 +: 8];
      a.rdy = cmd_ready;
      if (e.rwv) begin a.rnum = reg_wr_num; a.rval = reg_wr_val; end
      if (e.dmas) a.kind = dma_kind;
      nchecks++;
      if (a !== e) begin
        nfail++;
        $display("FAIL %s: actual addr=%h code=%h pend=%b arm=%b rwv=%b n=%0d v=%h dma=%b k=%0d wt=%0d rt=%0d r1=%h r15=%h r23=%h | expected addr=%h code=%h pend=%b arm=%b rwv=%b n=%0d v=%h dma=%b k=%0d wt=%0d rt=%0d r1=%h r15=%h r23=%h",
          r, a.addr, a.code, a.pend, a.armed, a.rwv, a.rnum, a.rval, a.dmas, a.kind, a.wt, a.rt, a.r1, a.r15, a.r23,
          e.addr, e.code, e.pend, e.armed, e.rwv, e.rnum, e.rval, e.dmas, e.kind, e.wt, e.rt, e.r1, e.r15, e.r23);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL R10 watchdog: actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 16'h0000, 0, 0, 0, "R10 reset state");
    step(1, 16'h8F02, 0, 0, 0, "R7 locked step write dropped");
    step(0, 16'h0000, 1, 0, 0, "R8 zero step leaves address");
    step(1, 16'h8114, 0, 0, 0, "R1 mode register write");
    step(1, 16'h8F02, 0, 0, 0, "R1 step write after unlock");
    step(1, 16'h4123, 0, 0, 0, "R2 first word sets pending");
    step(1, 16'h0002, 0, 0, 0, "R3 second word upper bits");
    step(0, 16'h0000, 1, 0, 0, "R8 write advances by step");
    step(0, 16'h0000, 0, 1, 0, "R8 read advances by step");
    step(1, 16'h4000, 0, 0, 0, "R2 first word keeps latched upper");
    step(0, 16'h0000, 0, 0, 1, "R6 status read clears pending");
    step(1, 16'h0000, 0, 0, 0, "R2 word after clear is first phase");
    step(0, 16'h0000, 1, 0, 0, "R6 data write clears pending");
    step(1, 16'hC000, 0, 0, 0, "R2 colour first word");
    step(1, 16'h0000, 0, 0, 0, "R9 colour RAM write target");
    step(1, 16'h0000, 0, 0, 0, "R2 read first word");
    step(1, 16'h0020, 0, 0, 0, "R9 colour RAM read target");
    step(1, 16'h0000, 0, 0, 0, "R2 read first word");
    step(0, 16'h0000, 0, 1, 0, "R6 data read clears pending");
    step(1, 16'h4000, 0, 0, 0, "R2 vscroll first word");
    step(1, 16'h0010, 0, 0, 0, "R9 vscroll write target");
    step(1, 16'h4000, 0, 0, 0, "R2 first word");
    step(1, 16'h8F05, 0, 0, 0, "R3 register pattern taken as second word");
    step(1, 16'h97C0, 0, 0, 0, "R1 select copy");
    step(1, 16'h4000, 0, 0, 0, "R2 copy first word");
    step(1, 16'h0080, 0, 0, 0, "R4 copy start pulse");
    step(0, 16'h0000, 0, 0, 0, "R4 copy pulse single cycle");
    step(1, 16'h9780, 0, 0, 0, "R1 select fill");
    step(1, 16'h4000, 0, 0, 0, "R2 fill first word");
    step(1, 16'h0081, 0, 0, 0, "R4 fill armed no pulse");
    step(0, 16'h0000, 0, 1, 0, "R5 read keeps fill armed");
    step(0, 16'h0000, 1, 0, 0, "R5 write launches fill");
    step(0, 16'h0000, 1, 0, 0, "R5 later write starts nothing");
    step(1, 16'h9740, 0, 0, 0, "R1 select external bus");
    step(1, 16'h4000, 0, 0, 0, "R2 bus first word");
    step(1, 16'h0080, 0, 0, 0, "R4 external bus pulse");
    step(1, 16'h8104, 0, 0, 0, "R1 clear transfer enable");
    step(1, 16'h4000, 0, 0, 0, "R2 first word");
    step(1, 16'h00F0, 0, 0, 0, "R4 disabled no transfer");
    step(1, 16'h8100, 0, 0, 0, "R1 relock");
    step(1, 16'h8F07, 0, 0, 0, "R7 relocked write dropped");
    step(0, 16'h0000, 0, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule